// File: doc/BRIEF.md
# Flash Page Command Issuer

This block is the host-side SPI master sequencer for page-level buffer operations on a serial flash. One request names an operation, a buffer, a page number and a page-size mode. The block builds a four-byte command (opcode, then three address bytes), shifts it out in SPI mode 0 and raises chip select. Raising chip select starts the operation inside the device.

After a short chip-select-high gap, the block opens one new chip-select-low window. It sends the status-read opcode once and then keeps clocking, reading the status bytes that the device repeats. It stops after the first byte that reports ready. At that point it pulses `done`, drops `busy` and, for a compare, reports the compare outcome on `mismatch`.

Request inputs are sampled only in the cycle in which `start` is accepted. The SPI clock runs at the system clock divided by `2*HALF_DIV`.

Top module: `flash_page_cmd`

## Requirements
- R1: The opcode depends on `op` and `buf_sel`. `op`=0 (load page into buffer) sends 53h or 55h. `op`=1 (compare page with buffer) sends 60h or 61h. `op`=2 (rewrite page through buffer) sends 58h or 59h. In each pair the first value is for `buf_sel`=0 and the second for `buf_sel`=1.
- R2: The command is one chip-select-low window of exactly 32 bits, sent MSB first: the opcode, then a 24-bit address. `spi_sclk` idles low. `spi_mosi` is stable at every rising `spi_sclk` edge. `spi_sclk` stays low whenever `spi_cs_n` is high.
- R3: With `bin_mode`=0, the 13-bit page occupies address bits 23:11 and address bits 10:0 are zero.
- R4: With `bin_mode`=1, the page occupies address bits 22:10. Address bit 23 and bits 9:0 are zero.
- R5: `spi_cs_n` stays high for at least 2 system clock rising edges between the end of the command and the start of the status poll.
- R6: The poll is a single chip-select-low window. It carries one D7h opcode and then status bytes, sampled MSB first on rising `spi_sclk`. The window ends right after the first status byte whose bit 7 is 1, so the number of status bytes read equals the number of busy bytes plus one.
- R7: `busy` is 1 from the cycle after an accepted `start` until the cycle in which `done` is 1. `done` is a single-cycle pulse, and `busy` is 0 in that cycle.
- R8: For `op`=1, `mismatch` takes bit 6 of the first ready status byte at `done`. For other operations it is 0. Bit 6 of busy status bytes has no effect. `mismatch` clears when a new request is accepted.
- R9: A `start` with `op`=3 is ignored, and so is a `start` while `busy` is 1. Neither one produces SPI activity, and neither one changes the command that is in progress.
- R10: After reset, `spi_cs_n`=1, `spi_sclk`=0, `spi_mosi`=0, and `busy`, `done` and `mismatch` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted while idle |
| op | input | 2 | 0 load, 1 compare, 2 rewrite, 3 invalid |
| buf_sel | input | 1 | Buffer select (0 or 1) |
| page | input | PAGE_W | Page number |
| bin_mode | input | 1 | 1 selects the power-of-two page-size address packing |
| spi_miso | input | 1 | Serial data from the flash |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| mismatch | output | 1 | Compare result, 1 means the page and buffer differ |

## Verification
The bench models the flash at the SPI pins. It rebuilds each command frame bit by bit and answers the poll with a chosen number of busy status bytes followed by a ready byte. Pages with all ones, a single set bit and alternating bits are sent in both modes. A design that shifts the page by the wrong amount, or lets it leak into bit 23 in binary mode, fails the frame comparison. Busy status bytes carry bit 6 set, so a design that latches the compare result from a busy byte, or ends the poll early, reports the wrong mismatch or the wrong number of status bytes. The invalid operation code and a second start during a running command are applied as well; a design that accepted either one would show an extra frame or a changed frame.

// File: rtl/flash_page_cmd.sv
module flash_page_cmd #(
  parameter int HALF_DIV = 2,
  parameter int GAP_CYC  = 2,
  parameter int PAGE_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic              buf_sel,
  input  logic [PAGE_W-1:0] page,
  input  logic              bin_mode,
  input  logic              spi_miso,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  output logic              busy,
  output logic              done,
  output logic              mismatch
);
  localparam int STD_PAD = 24 - PAGE_W;
  localparam int BIN_PAD = STD_PAD - 1;
  localparam int DIV_W   = $clog2(HALF_DIV + 1);
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_GAP, S_POLL_OP, S_POLL_RD} state_t;

  state_t           state;
  logic [31:0]      sh;
  logic [5:0]       bit_left;
  logic [DIV_W-1:0] div_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic             sclk_q, cs_q, rdy_q, cmp_q, is_cmp;
  logic [7:0]       opcode;
  logic [23:0]      addr;
  logic             accept, tick;

  always_comb begin
    case (op)
      2'd0:    opcode = buf_sel ? 8'h55 : 8'h53;
      2'd1:    opcode = buf_sel ? 8'h61 : 8'h60;
      default: opcode = buf_sel ? 8'h59 : 8'h58;
    endcase
  end

  assign addr   = bin_mode ? {1'b0, page, {BIN_PAD{1'b0}}} : {page, {STD_PAD{1'b0}}};
  assign accept = start && (op != 2'd3) && (state == S_IDLE);
  assign tick   = (div_cnt == DIV_W'(HALF_DIV - 1));

  assign spi_sclk = sclk_q;
  assign spi_cs_n = cs_q;
  assign spi_mosi = !cs_q && sh[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sh       <= '0;
      bit_left <= '0;
      div_cnt  <= '0;
      gap_cnt  <= '0;
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      rdy_q    <= 1'b0;
      cmp_q    <= 1'b0;
      is_cmp   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            state    <= S_CMD;
            sh       <= {opcode, addr};
            bit_left <= 6'd32;
            div_cnt  <= '0;
            sclk_q   <= 1'b0;
            cs_q     <= 1'b0;
            busy     <= 1'b1;
            mismatch <= 1'b0;
            is_cmp   <= (op == 2'd1);
          end
        end
        S_GAP: begin
          if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
            gap_cnt  <= '0;
            cs_q     <= 1'b0;
            sh       <= {8'hD7, 24'h0};
            bit_left <= 6'd8;
            state    <= S_POLL_OP;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: begin
          if (!tick) begin
            div_cnt <= div_cnt + 1'b1;
          end else begin
            div_cnt <= '0;
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              if (bit_left == 6'd8) rdy_q <= spi_miso;
              if (bit_left == 6'd7) cmp_q <= spi_miso;
            end else begin
              sclk_q   <= 1'b0;
              sh       <= {sh[30:0], 1'b0};
              bit_left <= bit_left - 1'b1;
              if (bit_left == 6'd1) begin
                case (state)
                  S_CMD: begin
                    cs_q  <= 1'b1;
                    state <= S_GAP;
                  end
                  S_POLL_OP: begin
                    bit_left <= 6'd8;
                    state    <= S_POLL_RD;
                  end
                  default: begin
                    if (rdy_q) begin
                      cs_q     <= 1'b1;
                      state    <= S_IDLE;
                      busy     <= 1'b0;
                      done     <= 1'b1;
                      mismatch <= is_cmp && cmp_q;
                    end else begin
                      bit_left <= 6'd8;
                    end
                  end
                endcase
              end
            end
          end
        end
      endcase
    end
  end

  assert_cs_idle_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  assert_gap_cs_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_GAP) |-> spi_cs_n);

  assert_busy_ends_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && spi_cs_n));

  assert_mismatch_rises_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mismatch) |-> done);

  assert_accept_only_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && $past(op) != 2'd3));

  assert_no_restart_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && $past(busy)) |-> $stable(is_cmp));
endmodule

// File: tb/flash_page_cmd_bench.sv
module flash_page_cmd_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        buf_sel = 1'b0;
  logic [12:0] page = '0;
  logic        bin_mode = 1'b0;
  logic        spi_miso;
  logic        spi_sclk, spi_cs_n, spi_mosi, busy, done, mismatch;

  flash_page_cmd u_flash_page_cmd (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .buf_sel(buf_sel),
    .page(page), .bin_mode(bin_mode), .spi_miso(spi_miso),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .busy(busy), .done(done), .mismatch(mismatch)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // flash model
  int          busy_bytes = 0;
  logic        cmp_bit = 1'b0;
  int          bits = 0;
  logic [31:0] shreg = '0;
  logic [7:0]  opc = '0;
  int          n_cmd = 0, n_poll = 0, last_cmd_bits = 0, last_poll_bytes = 0;
  logic [31:0] last_frame = '0;
  logic [7:0]  stat_byte;
  int          bitpos;

  always @(posedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      if (bits > 0) begin
        if (bits >= 8 && opc == 8'hD7) begin
          n_poll++;
          last_poll_bytes = (bits - 8) / 8;
        end else begin
          n_cmd++;
          last_frame    = shreg;
          last_cmd_bits = bits;
        end
      end
      bits = 0;
      opc  = '0;
    end else begin
      shreg = {shreg[30:0], spi_mosi};
      bits++;
      if (bits == 8) opc = shreg[7:0];
    end
  end

  assign stat_byte = (((bits - 8) / 8) < busy_bytes) ? 8'h7F : {1'b1, cmp_bit, 6'h15};
  assign bitpos    = 7 - ((bits - 8) % 8);
  assign spi_miso  = (!spi_cs_n && bits >= 8 && opc == 8'hD7) ? stat_byte[bitpos] : 1'b0;

  // chip-select gap measurement
  int   hi_cnt = 0, last_gap = 0;
  logic prev_cs = 1'b1;
  always @(posedge clk) begin
    if (prev_cs && !spi_cs_n) last_gap <= hi_cnt;
    hi_cnt  <= spi_cs_n ? hi_cnt + 1 : 0;
    prev_cs <= spi_cs_n;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] o, input logic b, input logic [12:0] p,
                       input logic m, input int bb, input logic cb);
    busy_bytes = bb;
    cmp_bit    = cb;
    op = o; buf_sel = b; page = p; bin_mode = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok, output int busy_gaps);
    ok = 0;
    busy_gaps = 0;
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      if (done) begin
        ok = 1;
        break;
      end
      if (!busy) busy_gaps++;
    end
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic        bsel;
    logic [12:0] page;
    logic        bin;
    logic [3:0]  bb;
    logic        cmp;
    logic [31:0] frame;
    logic        mm;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 1'b0, 13'h1ABC, 1'b0, 4'd1, 1'b0, 32'h53D5E000, 1'b0},
    '{2'd0, 1'b1, 13'h1FFF, 1'b1, 4'd0, 1'b1, 32'h557FFC00, 1'b0},
    '{2'd1, 1'b0, 13'h0001, 1'b0, 4'd3, 1'b1, 32'h60000800, 1'b1},
    '{2'd1, 1'b1, 13'h1000, 1'b1, 4'd0, 1'b0, 32'h61400000, 1'b0},
    '{2'd2, 1'b0, 13'h0155, 1'b0, 4'd2, 1'b1, 32'h580AA800, 1'b0},
    '{2'd2, 1'b1, 13'h1FFF, 1'b0, 4'd1, 1'b0, 32'h59FFF800, 1'b0},
    '{2'd1, 1'b0, 13'h0AAA, 1'b1, 4'd5, 1'b1, 32'h602AA800, 1'b1},
    '{2'd0, 1'b0, 13'h0000, 1'b1, 4'd0, 1'b1, 32'h53000000, 1'b0}
  };

  initial begin
    #(PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    int gaps, c0, p0;

    // R10 reset state
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && spi_mosi == 1'b0, "R10 spi idle",
        {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
    chk(busy == 1'b0 && done == 1'b0 && mismatch == 1'b0, "R10 flags",
        {busy, done, mismatch}, 3'b000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      c0 = n_cmd; p0 = n_poll;
      issue(VEC[i].op, VEC[i].bsel, VEC[i].page, VEC[i].bin, int'(VEC[i].bb), VEC[i].cmp);
      chk(busy == 1'b1, "R7 busy after start", busy, 1);
      chk(mismatch == 1'b0, "R8 mismatch cleared on start", mismatch, 0);
      wait_done(ok, gaps);
      chk(ok, "R7 done seen", ok, 1);
      chk(busy == 1'b0 && gaps == 0, "R7 busy window", gaps, 0);
      chk(last_frame == VEC[i].frame, "R1 R3 R4 command frame", last_frame, VEC[i].frame);
      chk(n_cmd - c0 == 1 && last_cmd_bits == 32, "R2 one 32-bit frame", last_cmd_bits, 32);
      chk(last_gap >= 2, "R5 cs gap", last_gap, 2);
      chk(n_poll - p0 == 1, "R6 single poll window", n_poll - p0, 1);
      chk(last_poll_bytes == int'(VEC[i].bb) + 1, "R6 status bytes read",
          last_poll_bytes, int'(VEC[i].bb) + 1);
      chk(mismatch == VEC[i].mm, "R8 mismatch", mismatch, VEC[i].mm);
      @(negedge clk);
      chk(done == 1'b0, "R7 done single pulse", done, 0);
      repeat (3) @(negedge clk);
    end

    // R9 invalid op ignored
    c0 = n_cmd; p0 = n_poll;
    issue(2'd3, 1'b1, 13'h0123, 1'b0, 0, 1'b0);
    chk(busy == 1'b0, "R9 op3 no busy", busy, 0);
    repeat (40) @(negedge clk);
    chk(n_cmd == c0 && n_poll == p0 && spi_cs_n == 1'b1, "R9 op3 no spi", n_cmd - c0, 0);

    // R9 start while busy ignored; R8 busy-byte bit 6 has no effect
    c0 = n_cmd; p0 = n_poll;
    issue(2'd1, 1'b0, 13'h0005, 1'b0, 4, 1'b0);
    repeat (10) @(negedge clk);
    op = 2'd2; page = 13'h1FFF; buf_sel = 1'b1; bin_mode = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok, gaps);
    chk(ok && gaps == 0, "R7 done after busy start", gaps, 0);
    chk(last_frame == 32'h60002800, "R9 frame unchanged", last_frame, 32'h60002800);
    chk(n_cmd - c0 == 1, "R9 no extra command", n_cmd - c0, 1);
    chk(last_poll_bytes == 5, "R6 status bytes read", last_poll_bytes, 5);
    chk(mismatch == 1'b0, "R8 busy byte bit6 ignored", mismatch, 0);
    repeat (40) @(negedge clk);
    chk(busy == 1'b0 && n_cmd - c0 == 1, "R9 no deferred start", n_cmd - c0, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule